// File: doc/BRIEF.md
# Dual Four-Mode Timer/Counter

This block holds two timer/counter channels. Both are set up through one shared byte-wide mode register and one shared control register. Each channel has a low and a high count byte. It advances either once per machine cycle (timer) or once per falling edge seen on its count pin (counter). Software can start and stop each channel with a run bit, and can also hand that decision to the channel's gate pin.

Each channel can run in one of these modes:
- a 13-bit counter whose low five bits act as a divide-by-32 prescaler;
- a full 16-bit wrapping counter;
- an 8-bit counter that reloads itself from the high byte on overflow.

A fourth mode, applied to channel 0, splits it into two independent 8-bit counters. The high half takes over channel 1's run bit and overflow flag, and channel 1 then runs free, for use as a rate source.

A system uses the block through a small register port and a machine-cycle enable pulse. An interrupt controller watches the two overflow flags and clears a flag with a one-clock strobe when it accepts that interrupt. A serial port can take channel 1's overflow pulse as its bit-rate tick. There is no streaming data path, so every pin is a plain control or status signal.

Top module: `dual_tmr_top`

## Requirements
- R1: After reset, every readable register (addresses 0 to 7) reads 00h, both overflow flags are 0 and the overflow pulse is 0.
- R2: Register addresses are: 0 mode, 1 control, 2 channel-0 low, 3 channel-0 high, 4 channel-1 low, 5 channel-1 high, and 6 and 7 read 00h. In the mode byte, channel 1 is the upper nibble and channel 0 the lower nibble. Each nibble is {gate-enable, counter-select, mode[1:0]}, MSB first. In the control byte, bit0 is run0, bit1 is run1, bit2 is flag0 and bit3 is flag1; bits 7:4 read 0.
- R3: Mode 00 counts the 13-bit value {high, low[4:0]}. Bits 7:5 of the low byte keep their value. A step from 1FFFh gives 0000h and sets the channel's flag.
- R4: Mode 01 counts {high, low} as 16 bits. A step from FFFFh gives 0000h, sets the flag, and counting goes on.
- R5: Mode 10 counts the low byte only. A step from FFh loads the low byte with the high byte, sets the flag, and leaves the high byte unchanged.
- R6: A channel steps only on a clock where mc_en is 1, its run bit is 1, and either its gate-enable bit is 0 or its gate pin is 1. With mc_en at 0, no count changes.
- R7: In counter mode, the count pin is sampled only on mc_en clocks. A step happens when the previous sample was 1 and the current one is 0. The previous sample resets to 0, and pin activity between mc_en clocks is not seen.
- R8: With channel 0 in mode 11, its low byte counts as an 8-bit counter under channel 0's controls and sets flag0. Its high byte steps on every mc_en clock while run1 is 1, ignoring gating and counter-select, and sets flag1 when it wraps. Channel 1 then steps without regard to run1, still subject to its own gating, and its overflow does not set flag1.
- R9: Channel 1 in mode 11 holds its count.
- R10: An overflow sets its flag. An ack_clr bit clears the matching flag, but an overflow in the same clock keeps it set. A write to the control register sets both flags to data bits 3:2, overriding both.
- R11: A write to a count byte stores the written data. In that clock the channel does not step or overflow. In split mode, only the half that was written is held.
- R12: ch1_ovf_pulse is 1 for exactly the clock after each overflow of channel 1's own counter, whatever the flag state.
- R13: Writing a run bit does not change the count registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mc_en | input | 1 | Machine-cycle enable pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address for read and write |
| reg_wdata | input | BYTE_W | Write data |
| reg_rdata | output | BYTE_W | Read data for reg_addr, combinational |
| cnt_pin | input | 2 | External count inputs, one per channel |
| gate_pin | input | 2 | External gate inputs, one per channel |
| ack_clr | input | 2 | Flag clear strobes on interrupt acknowledge |
| ovf_flag | output | 2 | Overflow flags, channel 1 in bit 1 |
| ch1_ovf_pulse | output | 1 | One-clock pulse after each channel-1 overflow |

## Verification
The assertions check the following properties on every cycle:
- the reload rule and the 16-bit wrap;
- that counts stay frozen without mc_en, and in channel 1's hold mode;
- that a write to a byte takes priority;
- that a low sample cannot be followed at once by a step;
- flag set-versus-acknowledge ordering, the split-mode masking of channel 1's flag, and pulse quiescence.

Only the bench scenarios can show the rest:
- the 13-bit prescaler boundary with preserved upper bits;
- edge counting across skipped machine cycles;
- the borrowed run bit in split mode;
- that run bits leave counts untouched;
- long mixed sequences against the bench's own reference model.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
  typedef enum logic [1:0] {
    MD_PRESC  = 2'b00,
    MD_WIDE   = 2'b01,
    MD_RELOAD = 2'b10,
    MD_SPLIT  = 2'b11
  } tmode_e;

  // One nibble of the mode register, MSB first
  typedef struct packed {
    logic   gate;
    logic   is_cnt;
    tmode_e mode;
  } chcfg_t;
endpackage

// File: rtl/dtmr_edge.sv
module dtmr_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mc_en,
  input  logic [N-1:0] pin,
  output logic [N-1:0] tick
);
  logic [N-1:0] prev_q;

  for (genvar i = 0; i < N; i++) begin : g_pin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     prev_q[i] <= 1'b0;
      else if (mc_en) prev_q[i] <= pin[i];
    end

    assign tick[i] = mc_en & prev_q[i] & ~pin[i];

    // R7: a low sample cannot be followed directly by a step
    assert_no_double_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mc_en && !pin[i]) |=> !tick[i]);
  end
endmodule

// File: rtl/dtmr_chan.sv
module dtmr_chan
  import dtmr_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int PRE_W     = 5,
  parameter bit SPLIT_CAP = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mc_en,
  input  chcfg_t            cfg,
  input  logic              run,
  input  logic              gate_pin,
  input  logic              pin_tick,
  input  logic              hi_run,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] lo_q,
  output logic [BYTE_W-1:0] hi_q,
  output logic              ovf_ev,
  output logic              hi_ovf_ev
);
  localparam int NARROW_W = BYTE_W + PRE_W;
  localparam int WIDE_W   = 2 * BYTE_W;
  localparam logic [BYTE_W-1:0] ONE_B = 1;
  localparam logic [NARROW_W:0] ONE_N = 1;
  localparam logic [WIDE_W:0]   ONE_W = 1;

  logic              en, any_wr;
  logic [NARROW_W:0] narrow_sum;
  logic [WIDE_W:0]   wide_sum;
  logic [BYTE_W-1:0] lo_n, hi_n;

  assign en     = mc_en & run & (~cfg.gate | gate_pin) & (cfg.is_cnt ? pin_tick : 1'b1);
  assign any_wr = wr_lo | wr_hi;

  assign narrow_sum = {1'b0, hi_q, lo_q[PRE_W-1:0]} + ONE_N;
  assign wide_sum   = {1'b0, hi_q, lo_q} + ONE_W;

  always_comb begin
    lo_n      = lo_q;
    hi_n      = hi_q;
    ovf_ev    = 1'b0;
    hi_ovf_ev = 1'b0;
    case (cfg.mode)
      MD_PRESC: begin
        if (en && !any_wr) begin
          hi_n             = narrow_sum[NARROW_W-1:PRE_W];
          lo_n[PRE_W-1:0]  = narrow_sum[PRE_W-1:0];
          ovf_ev           = narrow_sum[NARROW_W];
        end
      end
      MD_WIDE: begin
        if (en && !any_wr) begin
          {hi_n, lo_n} = wide_sum[WIDE_W-1:0];
          ovf_ev       = wide_sum[WIDE_W];
        end
      end
      MD_RELOAD: begin
        if (en && !any_wr) begin
          if (&lo_q) begin
            lo_n   = hi_q;
            ovf_ev = 1'b1;
          end else begin
            lo_n = lo_q + ONE_B;
          end
        end
      end
      default: begin
        if (SPLIT_CAP) begin
          if (en && !wr_lo) begin
            lo_n   = lo_q + ONE_B;
            ovf_ev = &lo_q;
          end
          if (mc_en && hi_run && !wr_hi) begin
            hi_n      = hi_q + ONE_B;
            hi_ovf_ev = &hi_q;
          end
        end
      end
    endcase
    if (wr_lo) lo_n = wdata;
    if (wr_hi) hi_n = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_n;
      hi_q <= hi_n;
    end
  end

  assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.mode == MD_RELOAD && en && (&lo_q) && !any_wr) |=> (lo_q == $past(hi_q)));

  assert_wide_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.mode == MD_WIDE && en && (&{hi_q, lo_q}) && !any_wr) |=> ({hi_q, lo_q} == '0));

  assert_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mc_en && !any_wr) |=> $stable({hi_q, lo_q}));

  assert_write_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> (lo_q == $past(wdata)));

  if (!SPLIT_CAP) begin : g_hold
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.mode == MD_SPLIT && !any_wr) |=> $stable({hi_q, lo_q}));
  end
endmodule

// File: rtl/dual_tmr_top.sv
module dual_tmr_top
  import dtmr_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int PRE_W  = 5,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mc_en,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic [1:0]        cnt_pin,
  input  logic [1:0]        gate_pin,
  input  logic [1:0]        ack_clr,
  output logic [1:0]        ovf_flag,
  output logic              ch1_ovf_pulse
);
  localparam logic [ADDR_W-1:0] A_MODE = 0;
  localparam logic [ADDR_W-1:0] A_CTRL = 1;
  localparam logic [ADDR_W-1:0] A_LO0  = 2;
  localparam logic [ADDR_W-1:0] A_HI0  = 3;
  localparam logic [ADDR_W-1:0] A_LO1  = 4;
  localparam logic [ADDR_W-1:0] A_HI1  = 5;
  localparam int CTRL_PAD = BYTE_W - 4;

  logic [BYTE_W-1:0] mode_q;
  logic [1:0]        run_q, flag_q, flag_n, set_v, tick;
  logic              pulse_q, split, wr_mode, wr_ctrl;
  chcfg_t            cfg0, cfg1;
  logic [BYTE_W-1:0] lo0, hi0, lo1, hi1;
  logic              ovf_ev0, hi_ovf_ev0, ovf_ev1, hi_ovf_ev1;

  assign cfg0    = chcfg_t'(mode_q[3:0]);
  assign cfg1    = chcfg_t'(mode_q[7:4]);
  assign split   = (cfg0.mode == MD_SPLIT);
  assign wr_mode = reg_wr && (reg_addr == A_MODE);
  assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);

  dtmr_edge #(.N(2)) edge_i (
    .clk(clk), .rst_n(rst_n), .mc_en(mc_en), .pin(cnt_pin), .tick(tick)
  );

  dtmr_chan #(.BYTE_W(BYTE_W), .PRE_W(PRE_W), .SPLIT_CAP(1'b1)) ch0_i (
    .clk(clk), .rst_n(rst_n), .mc_en(mc_en), .cfg(cfg0), .run(run_q[0]),
    .gate_pin(gate_pin[0]), .pin_tick(tick[0]), .hi_run(run_q[1]),
    .wr_lo(reg_wr && reg_addr == A_LO0), .wr_hi(reg_wr && reg_addr == A_HI0),
    .wdata(reg_wdata), .lo_q(lo0), .hi_q(hi0), .ovf_ev(ovf_ev0), .hi_ovf_ev(hi_ovf_ev0)
  );

  dtmr_chan #(.BYTE_W(BYTE_W), .PRE_W(PRE_W), .SPLIT_CAP(1'b0)) ch1_i (
    .clk(clk), .rst_n(rst_n), .mc_en(mc_en), .cfg(cfg1), .run(split | run_q[1]),
    .gate_pin(gate_pin[1]), .pin_tick(tick[1]), .hi_run(1'b0),
    .wr_lo(reg_wr && reg_addr == A_LO1), .wr_hi(reg_wr && reg_addr == A_HI1),
    .wdata(reg_wdata), .lo_q(lo1), .hi_q(hi1), .ovf_ev(ovf_ev1), .hi_ovf_ev(hi_ovf_ev1)
  );

  // Flag 1 belongs to channel 0's high half while split
  assign set_v[0] = ovf_ev0;
  assign set_v[1] = split ? hi_ovf_ev0 : (ovf_ev1 | hi_ovf_ev1);
  assign flag_n   = wr_ctrl ? reg_wdata[3:2] : ((flag_q & ~ack_clr) | set_v);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      run_q   <= '0;
      flag_q  <= '0;
      pulse_q <= 1'b0;
    end else begin
      if (wr_mode) mode_q <= reg_wdata;
      if (wr_ctrl) run_q  <= reg_wdata[1:0];
      flag_q  <= flag_n;
      pulse_q <= ovf_ev1;
    end
  end

  always_comb begin
    case (reg_addr)
      A_MODE:  reg_rdata = mode_q;
      A_CTRL:  reg_rdata = {{CTRL_PAD{1'b0}}, flag_q, run_q};
      A_LO0:   reg_rdata = lo0;
      A_HI0:   reg_rdata = hi0;
      A_LO1:   reg_rdata = lo1;
      A_HI1:   reg_rdata = hi1;
      default: reg_rdata = '0;
    endcase
  end

  assign ovf_flag      = flag_q;
  assign ch1_ovf_pulse = pulse_q;

  assert_ack_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_clr[0] && !set_v[0] && !wr_ctrl) |=> !ovf_flag[0]);

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (set_v[1] && !wr_ctrl) |=> ovf_flag[1]);

  assert_split_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (split && ovf_ev1 && !hi_ovf_ev0 && !wr_ctrl && !flag_q[1]) |=> !flag_q[1]);

  assert_pulse_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf_ev1 |=> !ch1_ovf_pulse);
endmodule

// File: tb/dual_tmr_top_tb_top.sv
module dual_tmr_top_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n, mc_en, reg_wr, ch1_ovf_pulse;
  logic [2:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic [1:0] cnt_pin, gate_pin, ack_clr, ovf_flag;

  dual_tmr_top dut_i (
    .clk(clk), .rst_n(rst_n), .mc_en(mc_en), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cnt_pin(cnt_pin), .gate_pin(gate_pin),
    .ack_clr(ack_clr), .ovf_flag(ovf_flag), .ch1_ovf_pulse(ch1_ovf_pulse)
  );

  int    errors = 0, checks = 0;
  string tag = "R1";
  bit    comparing = 1'b0;

  // Reference model state
  logic [7:0] m_mode, m_lo[2], m_hi[2];
  logic [1:0] m_run, m_flag, m_prev;
  logic       m_pulse;

  function automatic logic [7:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return m_mode;
      3'd1: return {4'b0, m_flag, m_run};
      3'd2: return m_lo[0];
      3'd3: return m_hi[0];
      3'd4: return m_lo[1];
      3'd5: return m_hi[1];
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_step();
    int v;
    bit split, runok, fire, hov;
    bit ov[2];
    bit wl, wh;
    bit [3:0] nb;
    bit [1:0] setv;
    if (!rst_n) begin
      m_mode = 0; m_run = 0; m_flag = 0; m_prev = 0; m_pulse = 0;
      for (int c = 0; c < 2; c++) begin m_lo[c] = 0; m_hi[c] = 0; end
      return;
    end
    split = (m_mode[1:0] == 2'b11);
    hov = 0;
    for (int c = 0; c < 2; c++) begin
      nb    = (c == 1) ? m_mode[7:4] : m_mode[3:0];
      runok = (c == 1 && split) ? 1'b1 : m_run[c];
      fire  = mc_en && runok && (!nb[3] || gate_pin[c]) &&
              (nb[2] ? (m_prev[c] && !cnt_pin[c]) : 1'b1);
      wl = reg_wr && (reg_addr == 3'(2 + 2 * c));
      wh = reg_wr && (reg_addr == 3'(3 + 2 * c));
      ov[c] = 0;
      case (nb[1:0])
        2'b00: if (fire && !wl && !wh) begin
          v = int'(m_hi[c]) * 32 + int'(m_lo[c]) % 32 + 1;
          if (v == 8192) begin v = 0; ov[c] = 1; end
          m_hi[c] = 8'(v / 32);
          m_lo[c] = (m_lo[c] & 8'hE0) | 8'(v % 32);
        end
        2'b01: if (fire && !wl && !wh) begin
          v = int'(m_hi[c]) * 256 + int'(m_lo[c]) + 1;
          if (v == 65536) begin v = 0; ov[c] = 1; end
          m_hi[c] = 8'(v / 256);
          m_lo[c] = 8'(v % 256);
        end
        2'b10: if (fire && !wl && !wh) begin
          if (m_lo[c] == 8'hFF) begin m_lo[c] = m_hi[c]; ov[c] = 1; end
          else m_lo[c] = m_lo[c] + 8'd1;
        end
        default: if (c == 0) begin
          if (fire && !wl) begin ov[c] = (m_lo[c] == 8'hFF); m_lo[c] = m_lo[c] + 8'd1; end
          if (mc_en && m_run[1] && !wh) begin hov = (m_hi[c] == 8'hFF); m_hi[c] = m_hi[c] + 8'd1; end
        end
      endcase
      if (wl) m_lo[c] = reg_wdata;
      if (wh) m_hi[c] = reg_wdata;
    end
    setv[0] = ov[0];
    setv[1] = split ? hov : ov[1];
    if (reg_wr && reg_addr == 3'd1) begin
      m_flag = reg_wdata[3:2];
      m_run  = reg_wdata[1:0];
    end else begin
      m_flag = (m_flag & ~ack_clr) | setv;
    end
    if (reg_wr && reg_addr == 3'd0) m_mode = reg_wdata;
    m_pulse = ov[1];
    if (mc_en) m_prev = cnt_pin;
  endtask

  always @(posedge clk) model_step();

  task automatic fail_line(input string what, input logic [15:0] got, input logic [15:0] exp);
    errors++;
    $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
  endtask

  always @(negedge clk) begin
    if (comparing) begin
      checks += 3;
      if (reg_rdata !== m_read(reg_addr)) fail_line("rdata", {8'h0, reg_rdata}, {8'h0, m_read(reg_addr)});
      if (ovf_flag !== m_flag) fail_line("flags", {14'h0, ovf_flag}, {14'h0, m_flag});
      if (ch1_ovf_pulse !== m_pulse) fail_line("pulse", {15'h0, ch1_ovf_pulse}, {15'h0, m_pulse});
    end
  end

  task automatic chk(input string t, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", t, got, exp);
    end
  endtask

  task automatic cyc(input bit mc);
    mc_en = mc;
    @(posedge clk);
    #2;
    mc_en = 0; reg_wr = 0; ack_clr = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d, input bit mc = 0);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    cyc(mc);
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [7:0] d, d2;
    void'($urandom(32'd4711));
    rst_n = 0; mc_en = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    cnt_pin = 0; gate_pin = 0; ack_clr = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    comparing = 1;

    tag = "R1";
    for (int a = 0; a < 8; a++) begin rd(3'(a), d); chk("R1 reset read", {8'h0, d}, 16'h0); end
    chk("R1 flags", {14'h0, ovf_flag}, 16'h0);
    chk("R1 pulse", {15'h0, ch1_ovf_pulse}, 16'h0);

    tag = "R2";
    wr(0, 8'hA5); rd(0, d); chk("R2 mode readback", {8'h0, d}, 16'h00A5);
    wr(1, 8'hFF); rd(1, d); chk("R2 ctrl readback", {8'h0, d}, 16'h000F);
    rd(6, d); chk("R2 unused address", {8'h0, d}, 16'h0);
    wr(1, 8'h00); wr(0, 8'h00);

    tag = "R3";
    wr(2, 8'hFE); wr(3, 8'hFF); wr(1, 8'h01);
    cyc(1); rd(2, d); chk("R3 low step", {8'h0, d}, 16'h00FF);
    cyc(1); rd(2, d); rd(3, d2);
    chk("R3 13-bit wrap", {d2, d}, 16'h00E0);
    chk("R3 flag0", {15'h0, ovf_flag[0]}, 16'h1);

    tag = "R10";
    ack_clr = 2'b01; cyc(0);
    chk("R10 ack clears", {15'h0, ovf_flag[0]}, 16'h0);
    wr(1, 8'h0C); rd(1, d); chk("R10 software set", {8'h0, d}, 16'h000C);
    wr(1, 8'h00); chk("R10 software clear", {14'h0, ovf_flag}, 16'h0);

    tag = "R4";
    wr(0, 8'h01); wr(2, 8'hFE); wr(3, 8'hFF); wr(1, 8'h01);
    cyc(1); rd(2, d); rd(3, d2); chk("R4 FFFF", {d2, d}, 16'hFFFF);
    cyc(1); rd(2, d); rd(3, d2); chk("R4 wrap", {d2, d}, 16'h0000);
    chk("R4 flag0", {15'h0, ovf_flag[0]}, 16'h1);
    cyc(1); rd(2, d); chk("R4 keeps counting", {8'h0, d}, 16'h0001);

    tag = "R5";
    wr(1, 8'h00); wr(0, 8'h02); wr(3, 8'hF0); wr(2, 8'hFF); wr(1, 8'h01);
    cyc(1); rd(2, d); rd(3, d2);
    chk("R5 reload", {d2, d}, 16'hF0F0);
    chk("R5 flag0", {15'h0, ovf_flag[0]}, 16'h1);
    tag = "R10";
    wr(2, 8'hFF); ack_clr = 2'b01; cyc(1);
    chk("R10 set beats ack", {15'h0, ovf_flag[0]}, 16'h1);

    tag = "R6";
    wr(1, 8'h00); wr(0, 8'h09); wr(2, 8'h00); wr(3, 8'h00); wr(1, 8'h01);
    gate_pin = 2'b00; repeat (3) cyc(1);
    rd(2, d); chk("R6 gate low blocks", {8'h0, d}, 16'h0);
    gate_pin = 2'b01; repeat (3) cyc(1);
    rd(2, d); chk("R6 gate high runs", {8'h0, d}, 16'h3);
    repeat (2) cyc(0);
    rd(2, d); chk("R6 no mc_en", {8'h0, d}, 16'h3);
    wr(1, 8'h00); repeat (2) cyc(1);
    rd(2, d); chk("R6 run off", {8'h0, d}, 16'h3);
    tag = "R13";
    wr(1, 8'h01); rd(2, d); chk("R13 run keeps count", {8'h0, d}, 16'h3);
    cyc(1); rd(2, d); chk("R13 resumes", {8'h0, d}, 16'h4);
    gate_pin = 2'b00;

    tag = "R7";
    wr(1, 8'h00); wr(0, 8'h05); wr(2, 8'h00); wr(3, 8'h00); wr(1, 8'h01);
    cnt_pin = 2'b01; cyc(1);
    cnt_pin = 2'b00; cyc(1);
    cyc(1);
    rd(2, d); chk("R7 one falling edge", {8'h0, d}, 16'h1);
    cnt_pin = 2'b01; cyc(1);
    cnt_pin = 2'b00; cyc(0);
    cnt_pin = 2'b01; cyc(1);
    rd(2, d); chk("R7 hidden pulse ignored", {8'h0, d}, 16'h1);
    cnt_pin = 2'b00; cyc(1);
    rd(2, d); chk("R7 second edge", {8'h0, d}, 16'h2);

    tag = "R8";
    wr(1, 8'h00); wr(0, 8'h03); wr(3, 8'hFE); wr(2, 8'h10); wr(1, 8'h02);
    cyc(1); cyc(1);
    rd(3, d); rd(2, d2); chk("R8 high half wraps, low idle", {d, d2}, 16'h0010);
    rd(1, d); chk("R8 flag1 from high half", {8'h0, d}, 16'h000A);
    wr(1, 8'h00); wr(0, 8'h13); wr(4, 8'hFE); wr(5, 8'hFF);
    cyc(1); cyc(1);
    rd(4, d); rd(5, d2); chk("R8 channel 1 free-runs", {d2, d}, 16'h0000);
    chk("R8 no flag1", {15'h0, ovf_flag[1]}, 16'h0);
    rd(3, d); chk("R8 high half held by run1", {8'h0, d}, 16'h0);
    tag = "R12";
    chk("R12 pulse", {15'h0, ch1_ovf_pulse}, 16'h1);
    cyc(0);
    chk("R12 pulse ends", {15'h0, ch1_ovf_pulse}, 16'h0);

    tag = "R9";
    wr(0, 8'h31); wr(4, 8'h05); wr(5, 8'h00); wr(1, 8'h02);
    repeat (3) cyc(1);
    rd(4, d); chk("R9 channel 1 holds", {8'h0, d}, 16'h5);

    tag = "R11";
    wr(1, 8'h00); wr(0, 8'h01); wr(2, 8'h10); wr(3, 8'h20); wr(1, 8'h01);
    wr(2, 8'h77, 1);
    rd(2, d); rd(3, d2); chk("R11 write beats step", {d2, d}, 16'h2077);
    cyc(1); rd(2, d); chk("R11 step after", {8'h0, d}, 16'h0078);
    wr(0, 8'h03); wr(1, 8'h03);
    wr(3, 8'h40, 1);
    rd(3, d); rd(2, d2); chk("R11 split half write", {d, d2}, 16'h4079);

    tag = "R6";
    for (int n = 0; n < 6000; n++) begin
      mc_en     = ($urandom % 3) == 0;
      cnt_pin   = 2'($urandom);
      gate_pin  = 2'($urandom);
      ack_clr   = (($urandom % 8) == 0) ? 2'($urandom) : 2'b00;
      reg_wr    = ($urandom % 6) == 0;
      reg_addr  = 3'($urandom);
      reg_wdata = 8'($urandom);
      if (reg_wr && reg_addr == 3'd0 && ($urandom % 2) == 0) reg_wdata[1:0] = 2'b11;
      @(posedge clk);
      #2;
    end
    mc_en = 0; reg_wr = 0; ack_clr = 0;
    @(posedge clk);
    #12;
    comparing = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule